// File: doc/BRIEF.md
# ZQ Calibration Quiet-Time Monitor

This block watches an already decoded DDR3 command stream and polices the silence the channel owes the memory after every impedance calibration command. A long calibration opens a quiet window whose length is the power-up length for the first long calibration after reset and the operating length after that. A short calibration opens the short window. While a window is open, any real command anywhere on the channel is a violation. This includes an ACTIVATE, a read, a precharge, or another calibration. The block reports the violation and the number of cycles by which the command came too early.

The monitor also tags traffic for a downstream trace store. The keep strobe marks only calibration commands and violating commands, so the store collects nothing else. Each tagged command carries a 32-bit cycle timestamp. Each violation also carries the distance in cycles to the previous violation, so that the violation rate can be read from the trace. The three window lengths are inputs, so that system software or a test harness can set them.

Top module: `zqmon_top`

## Requirements
- R1: Command codes on `cmd_code_i` are 0 idle (NOP/deselect), 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, 6 long calibration, 7 short calibration. A cycle with `cmd_valid_i` low, or with code 0, is not channel activity and never causes a violation.
- R2: The first long calibration after reset that opens a window uses `len_init_i`. Every later long calibration that opens a window uses `len_oper_i`.
- R3: A short calibration that opens a window uses `len_short_i`.
- R4: Suppose a calibration opens a window of length L at cycle t. A command at cycle t+k is a violation when 0 < k < L, and is legal when k >= L. A length of 0 or 1 opens no window.
- R5: The window covers the whole channel, so every non-idle code counts. On a violation, `early_o` equals L-k.
- R6: A calibration command inside an open window is itself a violation. It neither restarts nor extends the window, and it does not count as the first long calibration.
- R7: `keep_o` is high for every calibration command and every violating command, and low for all other commands. `keep_code_o` gives the tagged command's code.
- R8: A cycle counter starts at 0 when reset is released and advances by one on every clock. `keep_ts_o` is the counter value in the cycle the command was presented.
- R9: On a violation, `gap_o` is the timestamp difference to the previous violation since reset, or 0 for the first violation.
- R10: All outputs are registered and describe the command of the previous cycle. Under reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A decoded command is present |
| cmd_code_i | input | 3 | Decoded command code (see R1) |
| len_init_i | input | CNT_W | Quiet length for the first long calibration |
| len_oper_i | input | CNT_W | Quiet length for later long calibrations |
| len_short_i | input | CNT_W | Quiet length for short calibrations |
| keep_o | output | 1 | Trace-store qualify strobe |
| keep_code_o | output | 3 | Code of the tagged command |
| keep_ts_o | output | TS_W | Timestamp of the tagged command |
| viol_o | output | 1 | The tagged command broke a quiet window |
| early_o | output | CNT_W | Cycles by which the violating command was early |
| gap_o | output | TS_W | Cycles since the previous violation |

## Verification
Two functions can fall on one command. Calibration tagging and violation detection coincide when a long calibration is issued two cycles after a short one, while the short window is still open. The bench then checks that the command is kept once, flagged with the correct earliness, and does not restart the window: an ACTIVATE placed just after the short window's original end must pass clean. A later long calibration in the same run must still receive the power-up length.

// File: rtl/zqmon_pkg.sv
package zqmon_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CMD_IDLE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5,
        CMD_ZQCL = 3'd6,
        CMD_ZQCS = 3'd7
    } zq_cmd_e;
endpackage

// File: rtl/zqmon_window.sv
module zqmon_window #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             long_i,
    input  logic [CNT_W-1:0] len_init_i,
    input  logic [CNT_W-1:0] len_oper_i,
    input  logic [CNT_W-1:0] len_short_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] remain_o
);
    typedef struct packed {
        logic [CNT_W-1:0] remain;
        logic             long_seen;
    } win_t;

    win_t st_d, st_q;
    logic [CNT_W-1:0] sel_len;

    always_comb begin
        st_d    = st_q;
        sel_len = long_i ? (st_q.long_seen ? len_oper_i : len_init_i) : len_short_i;
        if (start_i) begin
            // remaining count after the calibration cycle itself
            st_d.remain = (sel_len == '0) ? '0 : sel_len - CNT_W'(1);
            if (long_i) st_d.long_seen = 1'b1;
        end else if (st_q.remain != '0) begin
            st_d.remain = st_q.remain - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o   = (st_q.remain != '0);
    assign remain_o = st_q.remain;
endmodule

// File: rtl/zqmon_stamp.sv
module zqmon_stamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now_o
);
    logic [TS_W-1:0] ts_d, ts_q;

    always_comb ts_d = ts_q + TS_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign now_o = ts_q;
endmodule

// File: rtl/zqmon_top.sv
module zqmon_top
    import zqmon_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int TS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [CODE_W-1:0] cmd_code_i,
    input  logic [CNT_W-1:0]  len_init_i,
    input  logic [CNT_W-1:0]  len_oper_i,
    input  logic [CNT_W-1:0]  len_short_i,
    output logic              keep_o,
    output logic [CODE_W-1:0] keep_code_o,
    output logic [TS_W-1:0]   keep_ts_o,
    output logic              viol_o,
    output logic [CNT_W-1:0]  early_o,
    output logic [TS_W-1:0]   gap_o
);
    typedef struct packed {
        logic              keep;
        logic [CODE_W-1:0] code;
        logic [TS_W-1:0]   ts;
        logic              viol;
        logic [CNT_W-1:0]  early;
        logic [TS_W-1:0]   gap;
        logic [TS_W-1:0]   last_ts;
        logic              have_prev;
    } out_t;

    out_t             o_d, o_q;
    logic             win_busy;
    logic [CNT_W-1:0] win_remain;
    logic [TS_W-1:0]  now_ts;
    logic             is_active, is_cal, is_long, hit, win_start;

    always_comb begin
        is_active = cmd_valid_i && (cmd_code_i != CMD_IDLE);
        is_long   = (cmd_code_i == CMD_ZQCL);
        is_cal    = cmd_valid_i && (is_long || cmd_code_i == CMD_ZQCS);
        hit       = is_active && win_busy;
        win_start = is_cal && !win_busy;
    end

    zqmon_window #(.CNT_W(CNT_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (win_start),
        .long_i     (is_long),
        .len_init_i (len_init_i),
        .len_oper_i (len_oper_i),
        .len_short_i(len_short_i),
        .busy_o     (win_busy),
        .remain_o   (win_remain)
    );

    zqmon_stamp #(.TS_W(TS_W)) u_stamp (
        .clk  (clk),
        .rst_n(rst_n),
        .now_o(now_ts)
    );

    always_comb begin
        o_d       = o_q;
        o_d.keep  = is_cal || hit;
        o_d.code  = cmd_code_i;
        o_d.ts    = now_ts;
        o_d.viol  = hit;
        o_d.early = hit ? win_remain : '0;
        o_d.gap   = '0;
        if (hit) begin
            o_d.gap       = o_q.have_prev ? (now_ts - o_q.last_ts) : '0;
            o_d.last_ts   = now_ts;
            o_d.have_prev = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign keep_o      = o_q.keep;
    assign keep_code_o = o_q.code;
    assign keep_ts_o   = o_q.ts;
    assign viol_o      = o_q.viol;
    assign early_o     = o_q.early;
    assign gap_o       = o_q.gap;
endmodule

// File: rtl/zqmon_checker.sv
module zqmon_checker #(
    parameter int CNT_W = 16,
    parameter int TS_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid_i,
    input logic [2:0]       cmd_code_i,
    input logic             busy,
    input logic [CNT_W-1:0] remain,
    input logic             keep_o,
    input logic             viol_o,
    input logic [CNT_W-1:0] early_o,
    input logic [TS_W-1:0]  stamp
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid_i || cmd_code_i == 3'd0) |=> !viol_o); // R1

    AST_VIOL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> $past(busy)); // R4

    AST_WIN_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (remain == $past(remain) - CNT_W'(1))); // R4

    AST_EARLY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (early_o != '0)); // R5

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid_i && cmd_code_i[2:1] == 2'b11) |=> (remain == $past(remain) - CNT_W'(1))); // R6

    AST_CAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i[2:1] == 2'b11) |=> keep_o); // R7

    AST_VIOL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> keep_o); // R7

    AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stamp == $past(stamp) + TS_W'(1))); // R8
endmodule

bind zqmon_top zqmon_checker #(.CNT_W(CNT_W), .TS_W(TS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid_i(cmd_valid_i),
    .cmd_code_i (cmd_code_i),
    .busy       (win_busy),
    .remain     (win_remain),
    .keep_o     (keep_o),
    .viol_o     (viol_o),
    .early_o    (early_o),
    .stamp      (now_ts)
);

// File: tb/zqmon_top_test.sv
module zqmon_top_test;
    localparam int CNT_W = 16;
    localparam int TS_W  = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid_i = 1'b0;
    logic [2:0]       cmd_code_i = 3'd0;
    logic [CNT_W-1:0] len_init_i = 16'd20;
    logic [CNT_W-1:0] len_oper_i = 16'd12;
    logic [CNT_W-1:0] len_short_i = 16'd6;
    logic             keep_o, viol_o;
    logic [2:0]       keep_code_o;
    logic [TS_W-1:0]  keep_ts_o, gap_o;
    logic [CNT_W-1:0] early_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk; // 50 MHz

    always @(posedge clk or negedge rst_n)
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;

    zqmon_top #(.CNT_W(CNT_W), .TS_W(TS_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i),
        .len_init_i(len_init_i), .len_oper_i(len_oper_i), .len_short_i(len_short_i),
        .keep_o(keep_o), .keep_code_o(keep_code_o), .keep_ts_o(keep_ts_o),
        .viol_o(viol_o), .early_o(early_o), .gap_o(gap_o)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", "keep under reset", keep_o, 0);
        chk("R10", "viol under reset", viol_o, 0);
        chk("R10", "ts under reset", keep_ts_o, 0);
        rst_n = 1'b1;
    endtask

    // present one command in cycle `target`, then check the registered result
    task automatic send_at(bit vld, int code, int target, bit exp_viol, int exp_early, int exp_gap, string req);
        int stamp;
        bit exp_keep;
        while (cyc < target) @(negedge clk);
        stamp = cyc;
        cmd_valid_i = vld;
        cmd_code_i = 3'(code);
        @(negedge clk);
        cmd_valid_i = 1'b0;
        exp_keep = exp_viol || (vld && code >= 6);
        chk(req, "viol", viol_o, exp_viol);
        chk("R7", "keep", keep_o, exp_keep);
        if (exp_keep) begin
            chk("R7", "code", keep_code_o, code);
            chk("R8", "timestamp", keep_ts_o, stamp);
        end
        if (exp_viol) begin
            chk("R5", "early", early_o, exp_early);
            chk("R9", "gap", gap_o, exp_gap);
        end
    endtask

    task automatic test_long();
        int t;
        do_reset();
        t = cyc + 1;
        send_at(1, 6, t, 0, 0, 0, "R2");
        send_at(1, 1, t + 10, 1, 10, 0, "R2");      // ACT inside init window
        send_at(1, 6, t + 20, 0, 0, 0, "R4");       // k == L: legal, opens oper window
        send_at(1, 4, t + 31, 1, 1, 21, "R2");      // PRE at k=11 of 12
        send_at(1, 2, t + 32, 0, 0, 0, "R4");       // k == 12: legal
    endtask

    task automatic test_short();
        int t;
        do_reset();
        t = cyc + 1;
        send_at(1, 7, t, 0, 0, 0, "R3");
        send_at(1, 0, t + 1, 0, 0, 0, "R1");        // valid NOP inside window
        send_at(0, 1, t + 2, 0, 0, 0, "R1");        // invalid ACT inside window
        send_at(1, 2, t + 5, 1, 1, 0, "R3");        // READ at k=5 of 6
        send_at(1, 3, t + 6, 0, 0, 0, "R4");        // WRITE at k=6: legal
    endtask

    task automatic test_cal_inside();
        int t;
        do_reset();
        t = cyc + 1;
        send_at(1, 7, t, 0, 0, 0, "R3");
        send_at(1, 6, t + 2, 1, 4, 0, "R6");        // calibration inside window
        send_at(1, 1, t + 6, 0, 0, 0, "R6");        // window not restarted
        send_at(1, 6, t + 8, 0, 0, 0, "R6");        // first real long cal: init length
        send_at(1, 4, t + 27, 1, 1, 25, "R6");      // k=19 of 20
        send_at(1, 5, t + 28, 0, 0, 0, "R4");
    endtask

    task automatic test_tiny_len();
        int t;
        do_reset();
        len_short_i = 16'd0;
        t = cyc + 1;
        send_at(1, 7, t, 0, 0, 0, "R4");
        send_at(1, 1, t + 1, 0, 0, 0, "R4");        // length 0: no window
        len_short_i = 16'd1;
        send_at(1, 7, t + 3, 0, 0, 0, "R4");
        send_at(1, 1, t + 4, 0, 0, 0, "R4");        // length 1: no window
        len_short_i = 16'd2;
        send_at(1, 7, t + 6, 0, 0, 0, "R4");
        send_at(1, 1, t + 7, 1, 1, 0, "R4");        // length 2: k=1 violates
        len_short_i = 16'd6;
    endtask

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_long();
        test_short();
        test_cal_inside();
        test_tiny_len();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule